// File: doc/BRIEF.md
# Per-Bank DDR Command Timing Guard

This block watches the command stream that a memory controller sends to a four-bank DDR SDRAM. It tracks each bank as idle or holding an open row, and it keeps one countdown for each minimum spacing between commands. Every command is judged in the cycle it is presented. A rejected command raises a violation flag and a numeric cause one cycle later. Alongside this, a combinational "legal now" vector tells a scheduler which command codes would be accepted in the current cycle for the bank and A10 value on the inputs.

All spacings are parameters counted in clock cycles. A spacing of N between two commands means the later command may come no earlier than N cycles after the earlier one. A READ or WRITE issued with A10 high schedules an implicit precharge at the end of its burst. The block treats that instant as a precharge of the bank and starts the bank's precharge-recovery countdown there.

The guard only observes. A command it flags is treated as never having been executed, so it changes no tracked state.

Top module: `ddr_cmd_guard`

## Requirements
- R1: Command codes are NOP=0, ACT=1, READ=2, WRITE=3, PRE=4, BST=5, AR=6, and code 7 is treated as NOP. `viol_o`/`viol_code_o` report the command presented in cycle t during cycle t+1. Bit c of `legal_now_o` is 1 exactly when code c would get cause 0 in the current cycle. NOP and BST are always legal, and after reset `legal_now_o` = 7'h73.
- R2: A READ or WRITE to an idle bank gets cause 1. An ACT to a bank that is open, or that is waiting for an implicit precharge, gets cause 2.
- R3: A READ or WRITE earlier than T_RCD cycles after the ACT of its bank gets cause 3.
- R4: An ACT earlier than T_RRD cycles after an accepted ACT to a different bank gets cause 4. Two ACTs to the same bank are not governed by T_RRD.
- R5: An ACT earlier than T_RP cycles after a precharge of its bank gets cause 5. An AR while any bank is inside its T_RP window also gets cause 5.
- R6: A PRE that targets an open bank gets cause 6 if it comes earlier than T_RAS cycles after that bank's ACT. It gets cause 7 if it comes earlier than BL/2 cycles after a READ to that bank.
- R7: A READ earlier than T_WTR cycles after any accepted WRITE gets cause 8.
- R8: An AR or an ACT earlier than T_RFC cycles after an accepted AR gets cause 9.
- R9: An AR while any bank is open gets cause 10.
- R10: A PRE with A10 high targets every bank. The R6 checks then apply to each open bank, and an accepted PRE closes all banks and starts T_RP for each of them.
- R11: A READ or WRITE with A10 high, accepted in cycle t, closes its bank at cycle t+BL/2 as if a PRE were issued there. A READ, WRITE or PRE to that bank from t+1 through t+BL/2 gets cause 11.
- R12: A command that is flagged changes no bank state and no spacing countdown.
- R13: When several causes apply, the first one in the following order is reported. ACT: 2, 5, 9, 4. READ: 1, 11, 3, 8. WRITE: 1, 11, 3. PRE: 11, 6, 7. AR: 10, 5, 9.
- R14: Burst code `bl_i` is 0 for BL=2, 1 for BL=4, and 2 or 3 for BL=8. It is sampled with each READ or WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; all banks idle, all countdowns clear |
| cmd_i | input | 3 | Decoded command code (R1) |
| bank_i | input | 2 | Bank address of the command |
| a10_i | input | 1 | A10: all-bank precharge or auto-precharge select |
| bl_i | input | 2 | Burst length code (R14) |
| legal_now_o | output | 7 | Per-code acceptance for the current bank and A10 (combinational) |
| viol_o | output | 1 | Previous cycle's command was rejected |
| viol_code_o | output | 4 | Cause of that rejection, 0 when none |

## Verification
`legal_now_o` is combinational, so the bench reads it 1 time unit after driving a command on the falling edge, before the rising edge that samples that command. `viol_o` and `viol_code_o` pass through one register, so the scoreboard pops the expected cause 1 time unit after the next rising edge. Each spacing boundary is placed by counting issued commands, NOPs included, from the reference command. Every timing rule is probed once one cycle short of the boundary and once at the boundary itself. The implicit precharge is checked by probing the cycles t+1, t+BL/2, t+BL/2+1 and t+BL/2+T_RP around a READ accepted in cycle t.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

  localparam int CMD_W     = 3;
  localparam int NUM_CMDS  = 7;
  localparam int CMD_SLOTS = 1 << CMD_W;
  localparam int ERR_W     = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_BST = 3'd5,
    CMD_AR  = 3'd6
  } cmd_e;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE     = 4'd0,
    ERR_IDLE_ACC = 4'd1,
    ERR_ROW_OPEN = 4'd2,
    ERR_RCD      = 4'd3,
    ERR_RRD      = 4'd4,
    ERR_RP       = 4'd5,
    ERR_RAS      = 4'd6,
    ERR_RD2PRE   = 4'd7,
    ERR_WTR      = 4'd8,
    ERR_RFC      = 4'd9,
    ERR_AR_OPEN  = 4'd10,
    ERR_AP_BUSY  = 4'd11
  } err_e;

  // Half the burst length in beats-per-clock terms (R14).
  function automatic int unsigned half_burst(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // Counter width that holds any of the given limits.
  function automatic int cnt_width(input int a, input int b, input int c,
                                   input int d, input int e, input int f);
    int m;
    m = 4;
    if (a > m) m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    if (f > m) m = f;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_go,
  input  logic          rd_go,
  input  logic          wr_go,
  input  logic          pre_go,
  input  logic          ap_req,
  input  logic [CW-1:0] half_bl,
  output logic          open_o,
  output logic          rcd_ok_o,
  output logic          ras_ok_o,
  output logic          rp_ok_o,
  output logic          rdp_ok_o,
  output logic          ap_busy_o,
  output logic          ap_close_o
);

  logic [CW-1:0] rcd_cnt, ras_cnt, rp_cnt, rdp_cnt, ap_cnt;
  logic          open_q, ap_pend;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] x);
    return (x == '0) ? x : x - CW'(1);
  endfunction

  assign ap_close_o = ap_pend && (ap_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      ap_pend <= 1'b0;
      rcd_cnt <= '0;
      ras_cnt <= '0;
      rp_cnt  <= '0;
      rdp_cnt <= '0;
      ap_cnt  <= '0;
    end else begin
      rcd_cnt <= step_down(rcd_cnt);
      ras_cnt <= step_down(ras_cnt);
      rp_cnt  <= step_down(rp_cnt);
      rdp_cnt <= step_down(rdp_cnt);
      ap_cnt  <= step_down(ap_cnt);
      if (act_go) begin
        open_q  <= 1'b1;
        rcd_cnt <= CW'(T_RCD - 1);
        ras_cnt <= CW'(T_RAS - 1);
      end
      if ((rd_go || wr_go) && ap_req) begin
        ap_pend <= 1'b1;
        ap_cnt  <= half_bl - CW'(1);
      end
      if (rd_go) rdp_cnt <= half_bl - CW'(1);
      if (pre_go || ap_close_o) begin
        open_q  <= 1'b0;
        rp_cnt  <= CW'(T_RP - 1);
      end
      if (ap_close_o) ap_pend <= 1'b0;
    end
  end

  assign open_o    = open_q;
  assign rcd_ok_o  = (rcd_cnt == '0);
  assign ras_ok_o  = (ras_cnt == '0);
  assign rp_ok_o   = (rp_cnt == '0);
  assign rdp_ok_o  = (rdp_cnt == '0);
  assign ap_busy_o = ap_pend;

endmodule

// File: rtl/ddr_global_gaps.sv
module ddr_global_gaps #(
  parameter int T_RRD = 2,
  parameter int T_WTR = 2,
  parameter int T_RFC = 8,
  parameter int CW    = 4,
  parameter int BA_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_go,
  input  logic [BA_W-1:0] act_bank,
  input  logic            wr_go,
  input  logic            ar_go,
  output logic            rrd_clear_o,
  output logic [BA_W-1:0] last_bank_o,
  output logic            wtr_ok_o,
  output logic            rfc_ok_o
);

  logic [CW-1:0]   rrd_cnt, wtr_cnt, rfc_cnt;
  logic [BA_W-1:0] last_bank;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] x);
    return (x == '0) ? x : x - CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_cnt   <= '0;
      wtr_cnt   <= '0;
      rfc_cnt   <= '0;
      last_bank <= '0;
    end else begin
      rrd_cnt <= act_go ? CW'(T_RRD - 1) : step_down(rrd_cnt);
      wtr_cnt <= wr_go  ? CW'(T_WTR - 1) : step_down(wtr_cnt);
      rfc_cnt <= ar_go  ? CW'(T_RFC - 1) : step_down(rfc_cnt);
      if (act_go) last_bank <= act_bank;
    end
  end

  assign rrd_clear_o = (rrd_cnt == '0);
  assign last_bank_o = last_bank;
  assign wtr_ok_o    = (wtr_cnt == '0);
  assign rfc_ok_o    = (rfc_cnt == '0);

endmodule

// File: rtl/ddr_cmd_judge.sv
module ddr_cmd_judge
  import ddr_guard_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input  logic [BA_W-1:0] bank_i,
  input  logic            a10_i,
  input  logic [NB-1:0]   open,
  input  logic [NB-1:0]   rcd_ok,
  input  logic [NB-1:0]   ras_ok,
  input  logic [NB-1:0]   rp_ok,
  input  logic [NB-1:0]   rdp_ok,
  input  logic [NB-1:0]   ap_busy,
  input  logic            rrd_clear,
  input  logic [BA_W-1:0] last_bank,
  input  logic            wtr_ok,
  input  logic            rfc_ok,
  output logic [CMD_SLOTS-1:0][ERR_W-1:0] err_v
);

  logic [NB-1:0] pre_sel;
  logic          rrd_hit;

  // Banks touched by a PRE: all of them with A10 high (R10).
  always_comb begin
    for (int b = 0; b < NB; b++)
      pre_sel[b] = a10_i || (bank_i == BA_W'(b));
  end

  assign rrd_hit = !rrd_clear && (last_bank != bank_i);

  // Priority chains per command code (R13).
  always_comb begin
    err_v = '0;
    if (open[bank_i] || ap_busy[bank_i]) err_v[CMD_ACT] = ERR_ROW_OPEN;
    else if (!rp_ok[bank_i])             err_v[CMD_ACT] = ERR_RP;
    else if (!rfc_ok)                    err_v[CMD_ACT] = ERR_RFC;
    else if (rrd_hit)                    err_v[CMD_ACT] = ERR_RRD;

    if (!open[bank_i])         err_v[CMD_RD] = ERR_IDLE_ACC;
    else if (ap_busy[bank_i])  err_v[CMD_RD] = ERR_AP_BUSY;
    else if (!rcd_ok[bank_i])  err_v[CMD_RD] = ERR_RCD;
    else if (!wtr_ok)          err_v[CMD_RD] = ERR_WTR;

    if (!open[bank_i])         err_v[CMD_WR] = ERR_IDLE_ACC;
    else if (ap_busy[bank_i])  err_v[CMD_WR] = ERR_AP_BUSY;
    else if (!rcd_ok[bank_i])  err_v[CMD_WR] = ERR_RCD;

    if (|(pre_sel & ap_busy))                 err_v[CMD_PRE] = ERR_AP_BUSY;
    else if (|(pre_sel & open & ~ras_ok))     err_v[CMD_PRE] = ERR_RAS;
    else if (|(pre_sel & open & ~rdp_ok))     err_v[CMD_PRE] = ERR_RD2PRE;

    if (|open)              err_v[CMD_AR] = ERR_AR_OPEN;
    else if (!(&rp_ok))     err_v[CMD_AR] = ERR_RP;
    else if (!rfc_ok)       err_v[CMD_AR] = ERR_RFC;
  end

endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard
  import ddr_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_WTR     = 2,
  parameter int T_RFC     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cmd_i,
  input  logic [1:0]          bank_i,
  input  logic                a10_i,
  input  logic [1:0]          bl_i,
  output logic [6:0]          legal_now_o,
  output logic                viol_o,
  output logic [3:0]          viol_code_o
);

  localparam int BA_W = $clog2(NUM_BANKS);
  localparam int CW   = cnt_width(T_RCD, T_RRD, T_RP, T_RAS, T_WTR, T_RFC);

  logic [CMD_SLOTS-1:0][ERR_W-1:0] err_all;
  logic [ERR_W-1:0] cmd_err;
  logic             cmd_ok;
  logic [CW-1:0]    half_bl;

  logic [NUM_BANKS-1:0] bank_open, rcd_ok, ras_ok, rp_ok, rdp_ok, ap_busy, ap_close;
  logic [NUM_BANKS-1:0] act_fire, rd_fire, wr_fire, pre_fire;
  logic                 ar_fire, any_act, any_wr;
  logic                 rrd_clear, wtr_ok, rfc_ok;
  logic [BA_W-1:0]      last_bank;

  assign half_bl = CW'(half_burst(bl_i));
  assign cmd_err = err_all[cmd_i];
  assign cmd_ok  = (cmd_err == ERR_NONE);
  assign ar_fire = cmd_ok && (cmd_i == CMD_AR);
  assign any_act = |act_fire;
  assign any_wr  = |wr_fire;

  always_comb begin
    for (int c = 0; c < NUM_CMDS; c++)
      legal_now_o[c] = (err_all[c] == ERR_NONE);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit         = (bank_i == BA_W'(b));
    assign act_fire[b] = cmd_ok && (cmd_i == CMD_ACT) && hit;
    assign rd_fire[b]  = cmd_ok && (cmd_i == CMD_RD)  && hit;
    assign wr_fire[b]  = cmd_ok && (cmd_i == CMD_WR)  && hit;
    assign pre_fire[b] = cmd_ok && (cmd_i == CMD_PRE) && (a10_i || hit);

    ddr_bank_track #(.T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .CW(CW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_go(act_fire[b]), .rd_go(rd_fire[b]), .wr_go(wr_fire[b]),
      .pre_go(pre_fire[b]), .ap_req(a10_i), .half_bl(half_bl),
      .open_o(bank_open[b]), .rcd_ok_o(rcd_ok[b]), .ras_ok_o(ras_ok[b]),
      .rp_ok_o(rp_ok[b]), .rdp_ok_o(rdp_ok[b]), .ap_busy_o(ap_busy[b]),
      .ap_close_o(ap_close[b])
    );
  end

  ddr_global_gaps #(.T_RRD(T_RRD), .T_WTR(T_WTR), .T_RFC(T_RFC), .CW(CW), .BA_W(BA_W)) u_gaps (
    .clk(clk), .rst_n(rst_n),
    .act_go(any_act), .act_bank(bank_i), .wr_go(any_wr), .ar_go(ar_fire),
    .rrd_clear_o(rrd_clear), .last_bank_o(last_bank),
    .wtr_ok_o(wtr_ok), .rfc_ok_o(rfc_ok)
  );

  ddr_cmd_judge #(.NB(NUM_BANKS), .BA_W(BA_W)) u_judge (
    .bank_i(bank_i), .a10_i(a10_i),
    .open(bank_open), .rcd_ok(rcd_ok), .ras_ok(ras_ok), .rp_ok(rp_ok),
    .rdp_ok(rdp_ok), .ap_busy(ap_busy),
    .rrd_clear(rrd_clear), .last_bank(last_bank),
    .wtr_ok(wtr_ok), .rfc_ok(rfc_ok),
    .err_v(err_all)
  );

  // One-cycle report of the verdict (R1).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_o      <= 1'b0;
      viol_code_o <= '0;
    end else begin
      viol_o      <= !cmd_ok;
      viol_code_o <= cmd_err;
    end
  end

endmodule

// File: rtl/ddr_guard_chk.sv
module ddr_guard_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cmd_i,
  input logic [6:0]    legal_now_o,
  input logic          viol_o,
  input logic          cmd_ok,
  input logic [NB-1:0] bank_open,
  input logic [NB-1:0] act_fire,
  input logic [NB-1:0] rd_fire,
  input logic [NB-1:0] wr_fire,
  input logic          ar_fire,
  input logic [NB-1:0] ap_close
);

  logic [7:0] legal_pad;
  assign legal_pad = {1'b1, legal_now_o};

  // R1: a code shown as not legal is flagged on the next cycle
  assert_illegal_flagged_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !legal_pad[cmd_i] |=> viol_o);

  // R4: at most one bank is activated per cycle
  assert_single_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_fire));

  // R9: refresh is accepted only with every bank idle
  assert_ar_all_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |-> (bank_open == '0));

  // R12: a rejected command leaves the open-row state alone
  assert_reject_keeps_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ok && ap_close == '0) |=> $stable(bank_open));

  for (genvar b = 0; b < NB; b++) begin : g_chk
    // R2: accepted ACT opens its bank; accepted accesses need an open bank
    assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      act_fire[b] |=> bank_open[b]);
    assert_access_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire[b] || wr_fire[b]) |-> bank_open[b]);
    // R11: the implicit precharge closes the bank
    assert_ap_closes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ap_close[b] |=> !bank_open[b]);
  end

endmodule

bind ddr_cmd_guard ddr_guard_chk #(.NB(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .legal_now_o(legal_now_o),
  .viol_o(viol_o), .cmd_ok(cmd_ok), .bank_open(bank_open),
  .act_fire(act_fire), .rd_fire(rd_fire), .wr_fire(wr_fire),
  .ar_fire(ar_fire), .ap_close(ap_close)
);

// File: tb/sim_ddr_cmd_guard.sv
module sim_ddr_cmd_guard;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, BST = 3'd5, AR = 3'd6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd_i = NOP;
  logic [1:0] bank_i = '0;
  logic       a10_i = 1'b0;
  logic [1:0] bl_i = '0;
  logic [6:0] legal_now_o;
  logic       viol_o;
  logic [3:0] viol_code_o;

  typedef struct {
    logic [3:0] code;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_cmd_guard u0 (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i),
    .a10_i(a10_i), .bl_i(bl_i), .legal_now_o(legal_now_o),
    .viol_o(viol_o), .viol_code_o(viol_code_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: present one command, check legality now, queue the verdict.
  task automatic issue(input logic [2:0] c, input int b, input bit a10,
                       input int bl, input int code, input string req);
    exp_t e;
    @(negedge clk);
    cmd_i  = c;
    bank_i = 2'(b);
    a10_i  = a10;
    bl_i   = 2'(bl);
    #1;
    chk(legal_now_o[c] == (code == 0), req, "legal_now", int'(legal_now_o[c]), int'(code == 0));
    e.code = 4'(code);
    e.req  = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(NOP, 0, 1'b0, 0, 0, "R1");
  endtask

  // Monitor: the verdict is registered on the edge after the command.
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      #1;
      cur = exp_q.pop_front();
      chk(viol_o == (cur.code != 0), cur.req, "viol_o", int'(viol_o), int'(cur.code != 0));
      chk(viol_code_o == cur.code, cur.req, "viol_code_o", int'(viol_code_o), int'(cur.code));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(legal_now_o == 7'h73, "R1", "legal_now after reset", int'(legal_now_o), 'h73);
    chk(viol_o == 1'b0, "R1", "viol_o after reset", int'(viol_o), 0);

    // Block A: R2, R3, R6, R5, R12
    issue(RD,  0, 0, 1, 1, "R2");   // read to idle bank
    issue(BST, 0, 0, 0, 0, "R1");
    issue(ACT, 0, 0, 0, 0, "R2");   // t0
    issue(RD,  0, 0, 1, 3, "R3");   // t0+1
    issue(RD,  0, 0, 1, 3, "R3");   // t0+2
    issue(RD,  0, 0, 1, 0, "R3");   // t0+3 boundary, BL4
    issue(ACT, 0, 0, 0, 2, "R2");   // t0+4 row already open
    issue(PRE, 0, 0, 0, 6, "R6");   // t0+5 tRAS short by one
    issue(PRE, 0, 0, 0, 0, "R12");  // t0+6 rejected ACT left tRAS alone
    issue(ACT, 0, 0, 0, 5, "R5");   // t0+7
    issue(NOP, 0, 0, 0, 0, "R1");   // t0+8
    issue(ACT, 0, 0, 0, 0, "R5");   // t0+9 boundary
    idle(6);
    issue(PRE, 0, 1, 0, 0, "R10");
    idle(10);

    // Block B: R4, R10
    issue(ACT, 1, 0, 0, 0, "R4");   // s
    issue(ACT, 2, 0, 0, 4, "R4");   // s+1
    issue(ACT, 2, 0, 0, 0, "R4");   // s+2 boundary
    issue(PRE, 0, 1, 0, 6, "R10");  // s+3 bank 1 inside tRAS
    idle(4);
    issue(PRE, 0, 1, 0, 0, "R10");  // s+8
    issue(ACT, 1, 0, 0, 5, "R10");  // s+9 precharge-all started tRP
    issue(NOP, 0, 0, 0, 0, "R1");
    issue(ACT, 1, 0, 0, 0, "R5");   // s+11
    idle(6);
    issue(PRE, 0, 1, 0, 0, "R10");
    idle(10);

    // Block C: R7, R6 read-to-precharge, R14 BL8
    issue(ACT, 3, 0, 0, 0, "R3");   // u
    idle(3);
    issue(WR,  3, 0, 2, 0, "R3");   // u+4
    issue(RD,  3, 0, 2, 8, "R7");   // u+5
    issue(RD,  3, 0, 2, 0, "R7");   // u+6 boundary, BL8
    issue(PRE, 3, 0, 0, 7, "R6");   // u+7
    issue(NOP, 0, 0, 0, 0, "R1");
    issue(PRE, 3, 0, 0, 7, "R14");  // u+9 still inside BL8/2
    issue(PRE, 3, 0, 0, 0, "R14");  // u+10
    idle(10);

    // Block D: R11 auto-precharge with BL4
    issue(ACT, 0, 0, 0, 0, "R11");  // v
    idle(2);
    issue(RD,  0, 1, 1, 0, "R11");  // v+3
    issue(RD,  0, 0, 1, 11, "R11"); // v+4
    issue(PRE, 0, 0, 0, 11, "R11"); // v+5 implicit precharge cycle
    issue(RD,  0, 0, 1, 1, "R11");  // v+6 bank now idle
    issue(ACT, 0, 0, 0, 5, "R11");  // v+7 tRP from v+5
    issue(ACT, 0, 0, 0, 0, "R11");  // v+8
    idle(6);
    issue(PRE, 0, 1, 0, 0, "R10");
    idle(10);

    // Block E: R9, R5, R8
    issue(ACT, 1, 0, 0, 0, "R9");   // w
    issue(AR,  0, 0, 0, 10, "R9");  // w+1
    idle(4);
    issue(PRE, 1, 0, 0, 0, "R6");   // w+6
    issue(AR,  0, 0, 0, 5, "R5");   // w+7
    issue(NOP, 0, 0, 0, 0, "R1");
    issue(AR,  0, 0, 0, 0, "R5");   // w+9
    issue(AR,  0, 0, 0, 9, "R8");   // w+10
    issue(ACT, 2, 0, 0, 9, "R8");   // w+11
    idle(5);
    issue(ACT, 2, 0, 0, 0, "R8");   // w+17 boundary

    // Block F: R13 priority, R14 BL2
    idle(2);
    issue(WR,  2, 0, 0, 0, "R13");  // w+20
    issue(RD,  3, 0, 0, 1, "R13");  // w+21 idle bank beats tWTR
    issue(RD,  2, 0, 0, 0, "R14");  // w+22 BL2
    issue(PRE, 2, 0, 0, 0, "R14");  // w+23 one cycle after BL2 read
    idle(2);

    @(negedge clk);
    finish_run();
  end

endmodule